// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product to a 64-bit signed accumulator. The accumulator is held as an upper and a lower 32-bit half and is read as `{acc_hi, acc_lo}`. It has two product forms. The long form multiplies both full 32-bit operands. The word form multiplies only the sign-extended low 16 bits of each operand. A one-cycle `start` strobe requests one accumulation. The new accumulator value appears one clock later, together with a one-cycle `done` pulse.

When `sat_en` is high, the sum is clamped after it is formed, and each form clamps differently. The long form limits only the upper half. A negative result has its top 16 upper-half bits forced to ones. A non-negative result has every upper-half bit above bit 14 cleared. The word form treats the accumulator as a 32-bit quantity. When the sum falls outside the signed 32-bit range, the upper half is set to 1 as an overflow marker and the lower half is set to the nearest 32-bit limit. A clear input and two direct load ports set the accumulator without going through the multiplier.

Top module: `sat_mac`

## Requirements
- R1: After reset, `acc_hi` and `acc_lo` are zero and `done` is low.
- R2: Long form (`op_word`=0): the accumulator gains the signed 64-bit product of `op_a` and `op_b`, both read as signed 32-bit values.
- R3: Word form (`op_word`=1): the product is formed from `op_a[15:0]` and `op_b[15:0]`, each sign-extended. Bits 31:16 of both operands have no effect on the result.
- R4: With `sat_en`=0, both forms write back the full 64-bit sum, which wraps modulo 2^64.
- R5: Long form with `sat_en`=1: a negative sum has `acc_hi[31:16]` set to all ones, with the other bits kept. A non-negative sum has `acc_hi[31:15]` cleared. `acc_lo` is written unchanged in both cases.
- R6: Word form with `sat_en`=1: a sum below -2^31 gives `acc_hi`=1 and `acc_lo`=0x80000000.
- R7: Word form with `sat_en`=1: a sum above 0x7FFFFFFF gives `acc_hi`=1 and `acc_lo`=0x7FFFFFFF. A sum inside the signed 32-bit range is written unchanged.
- R8: `clr` zeroes both halves on the next edge. It has priority over `start` and over the load ports in the same cycle.
- R9: The accumulator changes on the first clock edge after `start`. `done` is high for exactly that one cycle, and is low in every other cycle.
- R10: `ld_hi` and `ld_lo` write their data into the matching half on the next edge, each independently of the other. While either is high, `start` is ignored and `done` stays low.
- R11: In a cycle with no `clr`, no load and no `start`, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Zero the accumulator |
| start | input | 1 | Request one accumulation |
| op_word | input | 1 | 0: 32x32 long form, 1: 16x16 word form |
| sat_en | input | 1 | Enable saturation of the result |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| ld_hi | input | 1 | Write `ld_hi_data` into the upper half |
| ld_lo | input | 1 | Write `ld_lo_data` into the lower half |
| ld_hi_data | input | 32 | Preload value for the upper half |
| ld_lo_data | input | 32 | Preload value for the lower half |
| acc_hi | output | 32 | Upper accumulator half |
| acc_lo | output | 32 | Lower accumulator half |
| done | output | 1 | One-cycle pulse when an accumulation lands |

## Verification
The hardest case to reach through the operands alone is a clamp boundary. Reaching the word-form limits needs an accumulator already sitting near ±2^31. The long-form masks only show when the upper half holds bits above bit 15. Reaching either by repeated products would take long chains of operations. Instead, the bench preloads the accumulator through the load ports with values just inside and just outside these limits. From each preload it sweeps a grid of corner operands across both forms and both saturation settings, and compares every result against an arithmetic model.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic {
        OP_LONG = 1'b0,
        OP_WORD = 1'b1
    } mac_op_e;

    localparam int unsigned HALF_W = 32;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic              done;
    } mac_state_t;

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int unsigned OP_W   = 32,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned ACC_W = 2 * OP_W
) (
    input  mac_op_e          op,
    input  logic [OP_W-1:0]  a,
    input  logic [OP_W-1:0]  b,
    output logic [ACC_W-1:0] prod
);
    logic [ACC_W-1:0] ext_a;
    logic [ACC_W-1:0] ext_b;

    // One shared multiplier; the form only selects how operands are extended.
    always_comb begin
        if (op == OP_WORD) begin
            ext_a = {{(ACC_W-WORD_W){a[WORD_W-1]}}, a[WORD_W-1:0]};
            ext_b = {{(ACC_W-WORD_W){b[WORD_W-1]}}, b[WORD_W-1:0]};
        end else begin
            ext_a = {{(ACC_W-OP_W){a[OP_W-1]}}, a};
            ext_b = {{(ACC_W-OP_W){b[OP_W-1]}}, b};
        end
        prod = ext_a * ext_b;
    end

endmodule

// File: rtl/mac_clamp.sv
module mac_clamp
    import mac_pkg::*;
#(
    parameter int unsigned OP_W   = 32,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned ACC_W = 2 * OP_W
) (
    input  mac_op_e          op,
    input  logic             sat_en,
    input  logic [ACC_W-1:0] sum,
    output logic [ACC_W-1:0] res
);
    localparam logic [OP_W-1:0] NEG_SET  = {{(OP_W-WORD_W){1'b1}}, {WORD_W{1'b0}}};
    localparam logic [OP_W-1:0] POS_KEEP = {{(OP_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic [OP_W-1:0] LIM_NEG  = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [OP_W-1:0] LIM_POS  = {1'b0, {(OP_W-1){1'b1}}};
    localparam logic [OP_W-1:0] OVF_MARK = {{(OP_W-1){1'b0}}, 1'b1};

    logic [OP_W-1:0] hi_in;
    logic [OP_W-1:0] lo_in;
    logic            neg;
    logic            in_word_range;

    always_comb begin
        hi_in = sum[ACC_W-1:OP_W];
        lo_in = sum[OP_W-1:0];
        neg   = sum[ACC_W-1];
        // Fits in a signed OP_W value when all bits from OP_W-1 upward agree.
        in_word_range = (sum[ACC_W-1:OP_W-1] == '0) || (sum[ACC_W-1:OP_W-1] == '1);
        res = sum;
        if (sat_en) begin
            if (op == OP_LONG) begin
                res = {(neg ? (hi_in | NEG_SET) : (hi_in & POS_KEEP)), lo_in};
            end else if (!in_word_range) begin
                res = {OVF_MARK, (neg ? LIM_NEG : LIM_POS)};
            end
        end
    end

endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import mac_pkg::*;
#(
    parameter int unsigned OP_W   = 32,
    parameter int unsigned WORD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            start,
    input  logic            op_word,
    input  logic            sat_en,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic            ld_hi,
    input  logic            ld_lo,
    input  logic [OP_W-1:0] ld_hi_data,
    input  logic [OP_W-1:0] ld_lo_data,
    output logic [OP_W-1:0] acc_hi,
    output logic [OP_W-1:0] acc_lo,
    output logic            done
);
    localparam int unsigned ACC_W = 2 * OP_W;

    mac_state_t       st_d;
    mac_state_t       st_q;
    mac_op_e          op_sel;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] clamped;
    logic             ld_any;
    logic             acc_go;

    assign op_sel = mac_op_e'(op_word);
    assign ld_any = ld_hi | ld_lo;
    assign acc_go = start & ~clr & ~ld_any;

    mac_product #(.OP_W(OP_W), .WORD_W(WORD_W)) u_prod (
        .op   (op_sel),
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    assign sum = {st_q.hi, st_q.lo} + prod;

    mac_clamp #(.OP_W(OP_W), .WORD_W(WORD_W)) u_clamp (
        .op     (op_sel),
        .sat_en (sat_en),
        .sum    (sum),
        .res    (clamped)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr) begin
            st_d.hi = '0;
            st_d.lo = '0;
        end else if (ld_any) begin
            if (ld_hi) st_d.hi = ld_hi_data;
            if (ld_lo) st_d.lo = ld_lo_data;
        end else if (start) begin
            st_d.hi   = clamped[ACC_W-1:OP_W];
            st_d.lo   = clamped[OP_W-1:0];
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_hi = st_q.hi;
    assign acc_lo = st_q.lo;
    assign done   = st_q.done;

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0 && acc_lo == '0 && !done));

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> done);

    // R10
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start && !clr && !ld_hi && !ld_lo));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_hi && !ld_lo && !start) |=> ($stable(acc_hi) && $stable(acc_lo)));

    // R5
    long_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && sat_en && !op_word) |=>
            (acc_hi[OP_W-1:WORD_W] == '1 || acc_hi[OP_W-1:WORD_W-1] == '0));

    // R7
    word_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && sat_en && op_word) |=>
            (acc_hi == '0 || acc_hi == '1 || acc_hi == OP_W'(1)));

endmodule

// File: tb/sat_mac_test.sv
module sat_mac_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        start = 1'b0;
    logic        op_word = 1'b0;
    logic        sat_en = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        ld_hi = 1'b0;
    logic        ld_lo = 1'b0;
    logic [31:0] ld_hi_data = '0;
    logic [31:0] ld_lo_data = '0;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;
    logic        done;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    sat_mac uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .op_word(op_word),
        .sat_en(sat_en), .op_a(op_a), .op_b(op_b), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .ld_hi_data(ld_hi_data), .ld_lo_data(ld_lo_data),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    function automatic logic [63:0] model(logic [63:0] acc, logic [31:0] a, logic [31:0] b,
                                          logic w, logic s);
        longint p;
        longint r;
        logic [31:0] h;
        if (w) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        else   p = longint'($signed(a)) * longint'($signed(b));
        r = longint'(acc) + p;
        if (s && !w) begin
            h = r[63:32];
            if (r < 0) h = h | 32'hFFFF0000;
            else       h = h & 32'h00007FFF;
            r = {h, r[31:0]};
        end
        if (s && w) begin
            if (r < -64'sd2147483648)     r = {32'd1, 32'h80000000};
            else if (r > 64'sd2147483647) r = {32'd1, 32'h7FFFFFFF};
        end
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic preload(logic [63:0] v);
        @(negedge clk);
        ld_hi = 1'b1; ld_lo = 1'b1;
        ld_hi_data = v[63:32]; ld_lo_data = v[31:0];
        @(negedge clk);
        ld_hi = 1'b0; ld_lo = 1'b0;
    endtask

    task automatic accum(logic [31:0] a, logic [31:0] b, logic w, logic s);
        @(negedge clk);
        op_a = a; op_b = b; op_word = w; sat_en = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF,
                              32'h80000000, 32'h00007FFF, 32'hFFFF8000, 32'h1234ABCD};
    logic [63:0] pre [5] = '{64'h0, 64'h00000000_7FFFFFF0, 64'hFFFFFFFF_80000010,
                             64'h7FFFFFFF_FFFFFFFF, 64'h80000000_00000000};

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] exp;
        logic [63:0] acc;
        string tag;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset acc", {acc_hi, acc_lo}, 64'h0);
        check("R1 reset done", {63'h0, done}, 64'h0);
        rst_n = 1'b1;

        // Sweep: preload x form x saturation x operand grid
        for (int p = 0; p < 5; p++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int i = 0; i < 8; i++) begin
                        for (int j = 0; j < 8; j++) begin
                            preload(pre[p]);
                            accum(vals[i], vals[j], w[0], s[0]);
                            exp = model(pre[p], vals[i], vals[j], w[0], s[0]);
                            if (s == 0) tag = (w == 0) ? "R2 R4 long wrap" : "R3 R4 word wrap";
                            else if (w == 0) tag = "R5 long sat";
                            else if (exp == {32'd1, 32'h80000000}) tag = "R6 word low clamp";
                            else tag = "R7 word sat";
                            check(tag, {acc_hi, acc_lo}, exp);
                            check("R9 done pulse", {63'h0, done}, 64'h1);
                        end
                    end
                end
            end
        end

        // R9 done lasts one cycle; R11 hold without strobe
        preload(64'h0);
        accum(32'd7, 32'd9, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 done drops", {63'h0, done}, 64'h0);
        check("R11 hold", {acc_hi, acc_lo}, 64'd63);
        repeat (3) @(negedge clk);
        check("R11 hold long", {acc_hi, acc_lo}, 64'd63);

        // R3 upper operand bits ignored in word form
        accum(32'h12340003, 32'hABCD0005, 1'b1, 1'b0);
        check("R3 upper bits ignored", {acc_hi, acc_lo}, 64'd78);

        // Chained accumulations without reload
        acc = 64'd78;
        for (int k = 0; k < 6; k++) begin
            accum(32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0);
            acc = model(acc, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0);
            check("R2 chained", {acc_hi, acc_lo}, acc);
        end

        // R7 in-range word sat leaves value unchanged
        preload(64'hFFFFFFFF_FFFFFF00);
        accum(32'd16, 32'd2, 1'b1, 1'b1);
        check("R7 in range", {acc_hi, acc_lo}, 64'hFFFFFFFF_FFFFFF20);

        // R8 clear priority over start and load
        @(negedge clk);
        clr = 1'b1; start = 1'b1; ld_hi = 1'b1; ld_hi_data = 32'hDEAD;
        op_a = 32'd5; op_b = 32'd5;
        @(negedge clk);
        clr = 1'b0; start = 1'b0; ld_hi = 1'b0;
        check("R8 clear wins", {acc_hi, acc_lo}, 64'h0);
        check("R8 no done", {63'h0, done}, 64'h0);

        // R10 independent loads and start ignored during load
        @(negedge clk);
        ld_lo = 1'b1; ld_lo_data = 32'h55AA55AA; start = 1'b1;
        @(negedge clk);
        ld_lo = 1'b0; start = 1'b0;
        check("R10 lo only", {acc_hi, acc_lo}, 64'h00000000_55AA55AA);
        check("R10 start ignored", {63'h0, done}, 64'h0);
        @(negedge clk);
        ld_hi = 1'b1; ld_hi_data = 32'h01020304;
        @(negedge clk);
        ld_hi = 1'b0;
        check("R10 hi only", {acc_hi, acc_lo}, 64'h01020304_55AA55AA);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 async reset", {acc_hi, acc_lo}, 64'h0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule